// File: doc/BRIEF.md
# Telephone Keypad Matrix Scanner

This block reads a twelve-key telephone keypad built as a switch matrix with four row lines and three column lines. A pressed key joins one column line to one row line. The block drives the columns and reads the rows back. Each row input passes through a two-flop synchronizer before any decision is made on it. All scan decisions are made on a slow scan tick, which is an enable derived from the system clock. The tick period is set longer than the contact bounce time.

While idle, every column is driven high and the block waits for any row to read 1. The same row activity must then be seen again on the next tick before the press is trusted. The block then drives one column at a time in order, to find the column of the key. It decodes the row and the column into a 4-bit code and raises a valid strobe for one system clock cycle. After that it drives all columns high again and waits until no row reads 1. This gives a single strobe per press. If the key goes away before a column is found, the block returns to idle and raises no strobe.

Top module: `kpd_scan`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted, on the next clock edge `col_o` becomes 3'b111, `valid_o` becomes 0 and `key_o` becomes 4'b0000, and the block is in idle.
- R2: In idle, in confirm and in release-wait, `col_o` is 3'b111. During the column scan exactly one bit of `col_o` is 1. No other column pattern ever appears.
- R3: In idle, a nonzero synchronized row value seen on one tick moves the block to confirm. On the next tick, a zero row value sends it back to idle with no strobe. Row activity on only one tick never produces a strobe.
- R4: The scan drives `col_o[0]` alone, then `col_o[1]` alone, then `col_o[2]` alone, for one tick each, and moves to the next column only when the rows read all zero. Bit k of `col_o` drives keypad column k.
- R5: Row k of the keypad is `row_i[k]`. The codes are: row 0 holds keys 1, 2, 3 (codes 1, 2, 3); row 1 holds 4, 5, 6; row 2 holds 7, 8, 9; row 3 holds star = 4'b1010, zero = 4'b0000 and pound = 4'b1011. In each row the keys are listed for columns 0, 1, 2 in turn.
- R6: When a key is found, `valid_o` is 1 for exactly one clock cycle. On the same edge `key_o` takes the new code, and `key_o` keeps that value until the next strobe.
- R7: After a strobe, `col_o` stays 3'b111 until a tick on which the rows read all zero. Holding a key down for any length of time gives exactly one strobe, and release bounce shorter than one tick period gives none.
- R8: If no row reads 1 during the column 2 step, the block returns to idle without a strobe.
- R9: The FSM sees `row_i` two clock edges late, through two flops. `TICK_DIV` must be at least 3, so that the rows settle after each column change before the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_i | input | 4 | Keypad row sense lines, asynchronous |
| col_o | output | 3 | Keypad column drives |
| key_o | output | 4 | Code of the last recognized key |
| valid_o | output | 1 | One-cycle strobe when a key is recognized |

## Verification
The hardest case to reach from the ports is a key that disappears in the middle of the column scan. The stimulus holds a key in column 2 until it sees `col_o` change to the column 0 pattern. It then releases the key, so the column 2 step reads empty rows. A second hard case is activity that lasts for exactly one tick sample. To produce it, a press is held for as many clocks as one tick period, so the synchronized rows are high on only one tick. Bounce on press and on release is kept shorter than one tick period, so the exact pulse count can be predicted.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

    localparam int NROW   = 4;
    localparam int NCOL   = 3;
    localparam int CODE_W = 4;
    localparam int RIDX_W = $clog2(NROW);
    localparam int CIDX_W = $clog2(NCOL);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONF = 2'd1,
        ST_SCAN = 2'd2,
        ST_REL  = 2'd3
    } kpd_state_t;

    typedef struct packed {
        logic              hit;
        logic [CODE_W-1:0] code;
    } kpd_hit_t;

    // Keypad layout: row-major, columns left to right.
    function automatic logic [CODE_W-1:0] key_code(input logic [RIDX_W-1:0] r,
                                                    input logic [CIDX_W-1:0] c);
        logic [CODE_W-1:0] k;
        case ({r, c})
            {2'd0, 2'd0}: k = 4'd1;
            {2'd0, 2'd1}: k = 4'd2;
            {2'd0, 2'd2}: k = 4'd3;
            {2'd1, 2'd0}: k = 4'd4;
            {2'd1, 2'd1}: k = 4'd5;
            {2'd1, 2'd2}: k = 4'd6;
            {2'd2, 2'd0}: k = 4'd7;
            {2'd2, 2'd1}: k = 4'd8;
            {2'd2, 2'd2}: k = 4'd9;
            {2'd3, 2'd0}: k = 4'd10;
            {2'd3, 2'd1}: k = 4'd0;
            {2'd3, 2'd2}: k = 4'd11;
            default:      k = 4'd0;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/kpd_tick.sv
module kpd_tick #(
    parameter int DIV = 500000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick_o = (cnt == LAST);
endmodule

// File: rtl/kpd_decode.sv
module kpd_decode
    import kpd_pkg::*;
(
    input  logic [NROW-1:0]   row_i,
    input  logic [CIDX_W-1:0] cidx_i,
    output kpd_hit_t          hit_o
);
    logic [RIDX_W-1:0] ridx;

    // Lowest-numbered active row wins if several read high.
    always_comb begin
        ridx = '0;
        for (int r = NROW - 1; r >= 0; r--) begin
            if (row_i[r]) ridx = RIDX_W'(r);
        end
        hit_o.hit  = |row_i;
        hit_o.code = key_code(ridx, cidx_i);
    end
endmodule

// File: rtl/kpd_scan.sv
module kpd_scan
    import kpd_pkg::*;
#(
    parameter int TICK_DIV = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NROW-1:0]   row_i,
    output logic [NCOL-1:0]   col_o,
    output logic [CODE_W-1:0] key_o,
    output logic              valid_o
);
    localparam logic [CIDX_W-1:0] CIDX_LAST = CIDX_W'(NCOL - 1);

    logic [NROW-1:0]   row_s;
    logic              tick;
    logic              any_row;
    kpd_state_t        st;
    logic [CIDX_W-1:0] cidx;
    kpd_hit_t          hit;

    kpd_sync #(.W(NROW), .STAGES(2)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (row_i),
        .q_o (row_s)
    );

    kpd_tick #(.DIV(TICK_DIV)) i_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    kpd_decode i_decode (
        .row_i  (row_s),
        .cidx_i (cidx),
        .hit_o  (hit)
    );

    assign any_row = |row_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cidx    <= '0;
            key_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE: if (any_row) st <= ST_CONF;
                    ST_CONF: begin
                        cidx <= '0;
                        st   <= any_row ? ST_SCAN : ST_IDLE;
                    end
                    ST_SCAN: begin
                        if (hit.hit) begin
                            key_o   <= hit.code;
                            valid_o <= 1'b1;
                            st      <= ST_REL;
                        end else if (cidx == CIDX_LAST) begin
                            st <= ST_IDLE;
                        end else begin
                            cidx <= cidx + 1'b1;
                        end
                    end
                    ST_REL:  if (!any_row) st <= ST_IDLE;
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        if (st == ST_SCAN) col_o = NCOL'(1) << cidx;
        else               col_o = '1;
    end

    // Assertions
    p_cols_legal_r2: assert property (@(posedge clk) disable iff (rst)
        ($countones(col_o) == 1) || (col_o == '1));

    p_idle_needs_row_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && tick && !any_row) |=> (st == ST_IDLE && !valid_o));

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    p_valid_in_release_r6: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (st == ST_REL && col_o == '1));

    p_key_changes_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(key_o) |-> valid_o);

    p_code_legal_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (key_o <= 4'd11));

    p_release_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_REL && !(tick && !any_row)) |=> (st == ST_REL && !valid_o));

    p_vanish_to_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SCAN && cidx == CIDX_LAST && tick && !any_row)
            |=> (st == ST_IDLE && !valid_o));
endmodule

// File: tb/test_kpd_scan.sv
module test_kpd_scan;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] row_i;
    logic [2:0] col_o;
    logic [3:0] key_o;
    logic       valid_o;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // keypad model
    logic key_dn = 1'b0;
    int   key_r  = 0;
    int   key_c  = 0;

    always #5 clk = ~clk;

    kpd_scan #(.TICK_DIV(DIV)) i_kpd_scan (
        .clk     (clk),
        .rst     (rst),
        .row_i   (row_i),
        .col_o   (col_o),
        .key_o   (key_o),
        .valid_o (valid_o)
    );

    always_comb begin
        row_i = '0;
        for (int c = 0; c < 3; c++)
            if (key_dn && key_c == c && col_o[c]) row_i[key_r] = 1'b1;
    end

    function automatic int exp_code(int r, int c);
        if (r < 3) return r * 3 + c + 1;
        if (c == 0) return 10;
        if (c == 1) return 0;
        return 11;
    endfunction

    // behavioural reference model, advanced on every rising edge
    int   m_st = 0;    // 0 idle 1 confirm 2 scan 3 release
    int   m_col = 0;
    int   m_cnt = 0;
    logic [3:0] m_q1 = '0, m_q2 = '0;
    int   m_key = 0;
    bit   m_valid = 0;
    bit   started = 0;

    always @(posedge clk) begin
        logic [3:0] rs;
        bit         tk;
        started = 1;
        if (rst) begin
            m_st = 0; m_col = 0; m_cnt = 0; m_q1 = '0; m_q2 = '0;
            m_key = 0; m_valid = 0;
        end else begin
            rs = m_q2;
            tk = (m_cnt == DIV - 1);
            m_q2 = m_q1;
            m_q1 = row_i;
            m_cnt = tk ? 0 : m_cnt + 1;
            m_valid = 0;
            if (tk) begin
                if (m_st == 0) begin
                    if (rs != 0) m_st = 1;
                end else if (m_st == 1) begin
                    m_col = 0;
                    m_st = (rs != 0) ? 2 : 0;
                end else if (m_st == 2) begin
                    if (rs != 0) begin
                        int ri;
                        ri = 3;
                        for (int r = 3; r >= 0; r--) if (rs[r]) ri = r;
                        m_key = exp_code(ri, m_col);
                        m_valid = 1;
                        m_st = 3;
                    end else if (m_col == 2) m_st = 0;
                    else m_col = m_col + 1;
                end else begin
                    if (rs == 0) m_st = 0;
                end
            end
        end
    end

    function automatic logic [2:0] m_cols();
        return (m_st == 2) ? 3'(1 << m_col) : 3'b111;
    endfunction

    // monitor: per-clock comparison and event bookkeeping
    int         pulses = 0;
    int         last_code = -1;
    int         doubles = 0;
    bit         prev_valid = 0;
    logic [2:0] prev_col = 3'b111;
    logic [2:0] col_seq[$];

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (col_o !== m_cols()) begin
                errors++;
                $display("FAIL R2 R4 col_o actual=%b expected=%b", col_o, m_cols());
            end
            checks++;
            if (valid_o !== m_valid) begin
                errors++;
                $display("FAIL R6 R9 valid_o actual=%b expected=%b", valid_o, m_valid);
            end
            checks++;
            if (key_o !== 4'(m_key)) begin
                errors++;
                $display("FAIL R5 key_o actual=%0d expected=%0d", key_o, m_key);
            end
            if (valid_o === 1'b1) begin
                pulses++;
                last_code = int'(key_o);
                if (prev_valid) doubles++;
            end
            prev_valid = (valid_o === 1'b1);
            if (col_o !== prev_col) col_seq.push_back(col_o);
            prev_col = col_o;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic press_release(int r, int c, int hold);
        key_r = r; key_c = c; key_dn = 1'b1;
        step(hold);
        key_dn = 1'b0;
        step(24);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n0;
        step(3);
        // R1 reset values
        chk(col_o == 3'b111, "R1 col_o in reset", int'(col_o), 7);
        chk(valid_o == 1'b0, "R1 valid_o in reset", int'(valid_o), 0);
        chk(key_o == 4'd0, "R1 key_o in reset", int'(key_o), 0);
        rst = 1'b0;
        step(10);

        // R5 R6 R7: every key, one pulse each, right code
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 3; c++) begin
                n0 = pulses;
                col_seq.delete();
                press_release(r, c, 40);
                chk(pulses == n0 + 1, "R7 one pulse per press", pulses - n0, 1);
                chk(last_code == exp_code(r, c), "R5 key code", last_code, exp_code(r, c));
                chk(key_o == 4'(exp_code(r, c)), "R6 key_o held", int'(key_o), exp_code(r, c));
                if (c == 2) begin
                    // R4 column order 001, 010, 100, then all high
                    chk(col_seq.size() == 4, "R4 column steps", col_seq.size(), 4);
                    if (col_seq.size() == 4) begin
                        chk(col_seq[0] == 3'b001, "R4 first column", int'(col_seq[0]), 1);
                        chk(col_seq[1] == 3'b010, "R4 second column", int'(col_seq[1]), 2);
                        chk(col_seq[2] == 3'b100, "R4 third column", int'(col_seq[2]), 4);
                    end
                end
            end
        end

        // R3: activity on one tick only
        n0 = pulses;
        key_r = 1; key_c = 1; key_dn = 1'b1;
        step(DIV);
        key_dn = 1'b0;
        step(30);
        chk(pulses == n0, "R3 single-sample blip", pulses - n0, 0);
        chk(col_o == 3'b111, "R2 back in idle", int'(col_o), 7);

        // R8: key vanishes during the scan
        n0 = pulses;
        key_r = 0; key_c = 2; key_dn = 1'b1;
        for (int i = 0; i < 100 && col_o != 3'b001; i++) step(1);
        chk(col_o == 3'b001, "R4 scan reached column 0", int'(col_o), 1);
        key_dn = 1'b0;
        step(30);
        chk(pulses == n0, "R8 vanished key no pulse", pulses - n0, 0);
        chk(col_o == 3'b111, "R8 returned to idle", int'(col_o), 7);

        // R7: bounce on press and release, then long hold
        n0 = pulses;
        key_r = 3; key_c = 2;
        key_dn = 1'b1; step(1); key_dn = 1'b0; step(1); key_dn = 1'b1;
        step(40);
        key_dn = 1'b0; step(1); key_dn = 1'b1; step(1); key_dn = 1'b0;
        step(30);
        chk(pulses == n0 + 1, "R7 bounced press one pulse", pulses - n0, 1);
        chk(last_code == 11, "R5 pound code", last_code, 11);

        n0 = pulses;
        press_release(1, 1, 200);
        chk(pulses == n0 + 1, "R7 long hold one pulse", pulses - n0, 1);
        chk(last_code == 5, "R5 key five", last_code, 5);

        chk(doubles == 0, "R6 strobe width one cycle", doubles, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule